// File: doc/BRIEF.md
# Sharer Vector Encoder and Invalidation Fan-out

This block owns the sharer field of a directory entry in a machine of up to 512 nodes, split into eight octants of 64 nodes. While every sharer sits in a single octant, the field is a precise per-node vector of 64 bits tagged with the octant number. When a sharer from a second octant arrives, the field becomes a coarse vector. In that form, each bit stands for an aligned group of eight nodes across the whole machine. A coarse field stays coarse until the entry is cleared.

The update path takes one entry per cycle in either the 16-bit compact form or the expanded form. It widens a compact entry on entry and then applies a pass, add-sharer or clear operation. One cycle later it returns the expanded result, together with the narrowed compact view and a flag that tells whether the compact view is lossless.

The fan-out path takes an expanded entry and a requestor node ID. It emits one unicast invalidate per marked node over a valid/ready handshake, in ascending node order, and never sends to the requestor. A coarse bit expands to all eight nodes of its group. When the stream ends, the path pulses a done signal and reports how many messages were accepted, so that the reply can state how many acknowledgements to expect.

Top module: `sve_sharer_top`

## Requirements
- R1: After reset, res_valid, inv_busy, inv_valid and inv_done are all 0.
- R2: The expanded entry is 68 bits: bit 67 is the coarse flag, bits 66:64 are the octant and bits 63:0 are the vector. Adding node n to an empty entry (vector all zero) gives flag 0, octant n[8:6] and only vector bit n[5:0] set.
- R3: Adding node n to a full entry whose octant equals n[8:6] sets vector bit n[5:0] and keeps every other bit.
- R4: Adding a node from another octant to a full entry yields a coarse entry with flag 1 and octant 0. Coarse bit c is set when any earlier sharer lies in nodes 8c..8c+7, and bit n/8 is also set.
- R5: Adding node n to a coarse entry sets bit n/8, and the entry stays coarse. A clear operation (op code 2) returns an all-zero entry. Op code 0 passes the entry through, op code 1 adds a sharer.
- R6: With in_is_compact=1, the 16-bit input becomes vector bits 15:0, with all other bits and fields zero. With in_is_compact=0, the expanded input is used unchanged.
- R7: res_compact equals vector bits 15:0. res_compact_fit is 1 exactly when the result is full-mode, octant 0 and vector bits 63:16 are zero.
- R8: A result and its single-cycle res_valid pulse appear in the cycle after op_valid is sampled.
- R9: A full entry sends one invalidate to node octant*64+b for each set bit b, in strictly ascending node order.
- R10: A coarse entry sends invalidates to all eight nodes 8c..8c+7 of each set bit c, in strictly ascending order.
- R11: In both modes, no invalidate is ever sent to the requestor node captured at start.
- R12: While inv_valid is 1 and inv_ready is 0, inv_valid stays 1 and inv_node is unchanged. Each node is accepted exactly once.
- R13: When the stream ends, inv_done pulses for one cycle and inv_count equals the number of handshakes. An empty entry gives inv_done with count 0.
- R14: inv_start while inv_busy is 1 is ignored, and the running stream is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Update operation present |
| op_code | input | 2 | 0 pass, 1 add sharer, 2 clear |
| in_is_compact | input | 1 | Input entry is in compact form |
| in_compact | input | 16 | Compact input entry |
| in_entry | input | 68 | Expanded input entry |
| node_id | input | 9 | Sharer node to add |
| res_valid | output | 1 | Result valid pulse |
| res_entry | output | 68 | Expanded result entry |
| res_compact | output | 16 | Narrowed compact result |
| res_compact_fit | output | 1 | Compact result is lossless |
| inv_start | input | 1 | Start a fan-out |
| inv_entry | input | 68 | Entry to fan out |
| inv_req_node | input | 9 | Requestor node to exclude |
| inv_busy | output | 1 | Fan-out in progress |
| inv_valid | output | 1 | Invalidate message valid |
| inv_ready | input | 1 | Receiver accepts message |
| inv_node | output | 9 | Destination node of message |
| inv_done | output | 1 | Fan-out finished pulse |
| inv_count | output | 10 | Messages sent in last fan-out |

## Verification
On every cycle, the assertions check the properties of the output stream. They confirm that a stalled message holds its node, that accepted nodes rise strictly, that the requestor never appears, that the done count matches the handshakes seen, and that results follow one cycle after an operation. The exact contents of an entry can only be shown by the bench's scenarios. These cover the octant tag, the full-to-coarse folding of bits, the compact widening and narrowing, and the precise set of nodes a coarse bit expands to. The bench scenarios also show that a start arriving mid-stream is ignored.

// File: rtl/sve_pkg.sv
package sve_pkg;
    localparam int NODES     = 512;
    localparam int OCT_NODES = 64;
    localparam int GRP       = 8;
    localparam int CMP_W     = 16;

    localparam int VEC_W     = OCT_NODES;
    localparam int NODE_W    = $clog2(NODES);
    localparam int OCT_W     = $clog2(NODES / OCT_NODES);
    localparam int BIT_W     = $clog2(VEC_W);
    localparam int GRP_W     = $clog2(GRP);
    localparam int CNT_W     = $clog2(NODES + 1);
    localparam int GPO       = OCT_NODES / GRP;   // coarse bits per octant
    localparam int ENT_W     = 1 + OCT_W + VEC_W;

    typedef struct packed {
        logic               coarse;
        logic [OCT_W-1:0]   oct;
        logic [VEC_W-1:0]   vec;
    } entry_t;

    typedef enum logic [1:0] {
        OP_PASS  = 2'd0,
        OP_ADD   = 2'd1,
        OP_CLEAR = 2'd2
    } op_e;

    // Fold a full vector into the machine-wide coarse vector.
    function automatic logic [VEC_W-1:0] fold_coarse(entry_t e);
        logic [VEC_W-1:0] r;
        r = '0;
        for (int c = 0; c < VEC_W; c++) begin
            if (int'(e.oct) == (c / GPO))
                r[c] = |e.vec[(c % GPO) * GRP +: GRP];
        end
        return r;
    endfunction
endpackage

// File: rtl/sve_entry_upd.sv
module sve_entry_upd
    import sve_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic              in_is_compact,
    input  logic [CMP_W-1:0]  in_compact,
    input  entry_t            in_entry,
    input  logic [NODE_W-1:0] node_id,
    output logic              res_valid,
    output entry_t            res_entry,
    output logic [CMP_W-1:0]  res_compact,
    output logic              res_compact_fit
);
    typedef struct packed {
        logic   valid;
        entry_t ent;
    } upd_t;

    upd_t st_d, st_q;

    entry_t           src;
    entry_t           wide;
    logic [OCT_W-1:0] n_oct;
    logic [BIT_W-1:0] n_bit;
    logic [BIT_W-1:0] n_grp;

    always_comb begin
        wide = '0;
        wide.vec[CMP_W-1:0] = in_compact;
        src   = in_is_compact ? wide : in_entry;
        n_oct = node_id[NODE_W-1 -: OCT_W];
        n_bit = node_id[BIT_W-1:0];
        n_grp = node_id[NODE_W-1 -: BIT_W];

        st_d       = st_q;
        st_d.valid = op_valid;
        if (op_valid) begin
            st_d.ent = src;
            case (op_e'(op_code))
                OP_ADD: begin
                    if (src.vec == '0) begin
                        st_d.ent        = '0;
                        st_d.ent.oct    = n_oct;
                        st_d.ent.vec[n_bit] = 1'b1;
                    end else if (!src.coarse && src.oct == n_oct) begin
                        st_d.ent.vec[n_bit] = 1'b1;
                    end else if (!src.coarse) begin
                        st_d.ent.coarse = 1'b1;
                        st_d.ent.oct    = '0;
                        st_d.ent.vec    = fold_coarse(src);
                        st_d.ent.vec[n_grp] = 1'b1;
                    end else begin
                        st_d.ent.vec[n_grp] = 1'b1;
                    end
                end
                OP_CLEAR: st_d.ent = '0;
                default:  st_d.ent = src;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid       = st_q.valid;
    assign res_entry       = st_q.ent;
    assign res_compact     = st_q.ent.vec[CMP_W-1:0];
    assign res_compact_fit = !st_q.ent.coarse && (st_q.ent.oct == '0) &&
                             (st_q.ent.vec[VEC_W-1:CMP_W] == '0);
endmodule

// File: rtl/sve_lowbit.sv
module sve_lowbit #(
    parameter int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/sve_fanout.sv
module sve_fanout
    import sve_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  entry_t            entry,
    input  logic [NODE_W-1:0] req_node,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NODE_W-1:0] out_node,
    output logic              done,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic              busy;
        logic              coarse;
        logic [OCT_W-1:0]  oct;
        logic [NODE_W-1:0] req;
        logic [VEC_W-1:0]  mask;
        logic [GRP_W-1:0]  sub;
        logic [CNT_W-1:0]  cnt;
        logic              done;
    } fan_t;

    fan_t fs_d, fs_q;

    logic [BIT_W-1:0]  low;
    logic              any;
    logic [NODE_W-1:0] cand;
    logic              is_req;
    logic              step;

    sve_lowbit #(.W(VEC_W)) u_low (
        .vec (fs_q.mask),
        .idx (low),
        .any (any)
    );

    always_comb begin
        cand = fs_q.coarse
             ? NODE_W'(low) * NODE_W'(GRP) + NODE_W'(fs_q.sub)
             : NODE_W'(fs_q.oct) * NODE_W'(OCT_NODES) + NODE_W'(low);
        is_req    = (cand == fs_q.req);
        out_valid = fs_q.busy && any && !is_req;
        step      = fs_q.busy && any && (is_req || out_ready);

        fs_d      = fs_q;
        fs_d.done = 1'b0;
        if (!fs_q.busy) begin
            if (start) begin
                fs_d.busy   = 1'b1;
                fs_d.coarse = entry.coarse;
                fs_d.oct    = entry.oct;
                fs_d.mask   = entry.vec;
                fs_d.req    = req_node;
                fs_d.sub    = '0;
                fs_d.cnt    = '0;
            end
        end else if (!any) begin
            fs_d.busy = 1'b0;
            fs_d.done = 1'b1;
        end else if (step) begin
            if (!is_req) fs_d.cnt = fs_q.cnt + 1'b1;
            if (!fs_q.coarse || fs_q.sub == GRP_W'(GRP - 1)) begin
                fs_d.mask[low] = 1'b0;
                fs_d.sub       = '0;
            end else begin
                fs_d.sub = fs_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign busy     = fs_q.busy;
    assign out_node = cand;
    assign done     = fs_q.done;
    assign count    = fs_q.cnt;
endmodule

// File: rtl/sve_sharer_top.sv
module sve_sharer_top
    import sve_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic              in_is_compact,
    input  logic [CMP_W-1:0]  in_compact,
    input  logic [ENT_W-1:0]  in_entry,
    input  logic [NODE_W-1:0] node_id,
    output logic              res_valid,
    output logic [ENT_W-1:0]  res_entry,
    output logic [CMP_W-1:0]  res_compact,
    output logic              res_compact_fit,
    input  logic              inv_start,
    input  logic [ENT_W-1:0]  inv_entry,
    input  logic [NODE_W-1:0] inv_req_node,
    output logic              inv_busy,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [NODE_W-1:0] inv_node,
    output logic              inv_done,
    output logic [CNT_W-1:0]  inv_count
);
    entry_t upd_res;

    sve_entry_upd u_upd (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_valid        (op_valid),
        .op_code         (op_code),
        .in_is_compact   (in_is_compact),
        .in_compact      (in_compact),
        .in_entry        (entry_t'(in_entry)),
        .node_id         (node_id),
        .res_valid       (res_valid),
        .res_entry       (upd_res),
        .res_compact     (res_compact),
        .res_compact_fit (res_compact_fit)
    );

    assign res_entry = upd_res;

    sve_fanout u_fan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (inv_start),
        .entry     (entry_t'(inv_entry)),
        .req_node  (inv_req_node),
        .busy      (inv_busy),
        .out_valid (inv_valid),
        .out_ready (inv_ready),
        .out_node  (inv_node),
        .done      (inv_done),
        .count     (inv_count)
    );
endmodule

// File: rtl/sve_sharer_chk.sv
module sve_sharer_chk
    import sve_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              res_valid,
    input logic              inv_start,
    input logic [NODE_W-1:0] inv_req_node,
    input logic              inv_busy,
    input logic              inv_valid,
    input logic              inv_ready,
    input logic [NODE_W-1:0] inv_node,
    input logic              inv_done,
    input logic [CNT_W-1:0]  inv_count
);
    logic [NODE_W-1:0] req_cap;
    logic [NODE_W-1:0] last_node;
    logic              seen;
    logic [CNT_W-1:0]  hs_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cap   <= '0;
            last_node <= '0;
            seen      <= 1'b0;
            hs_cnt    <= '0;
        end else if (inv_start && !inv_busy) begin
            req_cap <= inv_req_node;
            seen    <= 1'b0;
            hs_cnt  <= '0;
        end else if (inv_valid && inv_ready) begin
            last_node <= inv_node;
            seen      <= 1'b1;
            hs_cnt    <= hs_cnt + 1'b1;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && !inv_ready |=> inv_valid && $stable(inv_node)); // R12
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && seen |-> inv_node > last_node); // R9
    AST_NO_REQUESTOR: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_node != req_cap); // R11
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> inv_count == hs_cnt); // R13
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_busy); // R12
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid)); // R8
endmodule

bind sve_sharer_top sve_sharer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .res_valid    (res_valid),
    .inv_start    (inv_start),
    .inv_req_node (inv_req_node),
    .inv_busy     (inv_busy),
    .inv_valid    (inv_valid),
    .inv_ready    (inv_ready),
    .inv_node     (inv_node),
    .inv_done     (inv_done),
    .inv_count    (inv_count)
);

// File: tb/sve_sharer_top_tb.sv
module sve_sharer_top_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        op_valid = 0;
    logic [1:0]  op_code = 0;
    logic        in_is_compact = 0;
    logic [15:0] in_compact = 0;
    logic [67:0] in_entry = 0;
    logic [8:0]  node_id = 0;
    logic        res_valid;
    logic [67:0] res_entry;
    logic [15:0] res_compact;
    logic        res_compact_fit;
    logic        inv_start = 0;
    logic [67:0] inv_entry = 0;
    logic [8:0]  inv_req_node = 0;
    logic        inv_busy;
    logic        inv_valid;
    logic        inv_ready = 0;
    logic [8:0]  inv_node;
    logic        inv_done;
    logic [9:0]  inv_count;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sve_sharer_top u_dut (.*);

    task automatic chk(input bit ok, input string what, input logic [67:0] act,
                       input logic [67:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [67:0] mk(input bit coarse, input int oct,
                                       input logic [63:0] v);
        return {coarse, 3'(oct), v};
    endfunction

    function automatic logic [63:0] bits(input int a, input int b, input int c);
        logic [63:0] r = '0;
        if (a >= 0) r[a] = 1'b1;
        if (b >= 0) r[b] = 1'b1;
        if (c >= 0) r[c] = 1'b1;
        return r;
    endfunction

    task automatic do_op(input int code, input bit cmp, input logic [15:0] c,
                         input logic [67:0] e, input int node);
        @(negedge clk);
        op_valid = 1; op_code = 2'(code); in_is_compact = cmp;
        in_compact = c; in_entry = e; node_id = 9'(node);
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic check_res(input string tag, input logic [67:0] exp,
                             input bit exp_fit);
        chk(res_valid === 1'b1, {tag, " res_valid"}, 68'(res_valid), 68'd1);
        chk(res_entry === exp, {tag, " entry"}, res_entry, exp);
        chk(res_compact === exp[15:0], {tag, " compact"}, 68'(res_compact), 68'(exp[15:0]));
        chk(res_compact_fit === exp_fit, {tag, " fit"}, 68'(res_compact_fit), 68'(exp_fit));
    endtask

    task automatic t_reset();
        chk(res_valid === 0 && inv_busy === 0 && inv_valid === 0 && inv_done === 0,
            "R1 reset outputs", {64'd0, res_valid, inv_busy, inv_valid, inv_done}, 68'd0);
    endtask

    task automatic t_update();
        logic [67:0] e;
        // R2: empty entry, node 77 = octant 1, bit 13
        do_op(1, 0, 0, 68'd0, 77);
        e = mk(0, 1, bits(13, -1, -1));
        check_res("R2 add to empty", e, 0);
        // R3: same octant, node 100 -> bit 36
        do_op(1, 0, 0, e, 100);
        e = mk(0, 1, bits(13, 36, -1));
        check_res("R3 add same octant", e, 0);
        // R4: node 300 from octant 4 -> coarse groups 9, 12, 37
        do_op(1, 0, 0, e, 300);
        e = mk(1, 0, bits(9, 12, 37));
        check_res("R4 fold to coarse", e, 0);
        // R5: coarse add node 5 -> group 0, stays coarse
        do_op(1, 0, 0, e, 5);
        e = mk(1, 0, bits(9, 12, 37) | bits(0, -1, -1));
        check_res("R5 coarse add", e, 0);
        // R5: coarse add of a node inside an already-set group leaves it
        do_op(1, 0, 0, e, 76);
        check_res("R5 coarse add same group", e, 0);
        do_op(2, 0, 0, e, 0);
        check_res("R5 clear", 68'd0, 1);
        // R6/R7: compact widen and pass
        do_op(0, 1, 16'hA5C3, 68'hF_FFFF_FFFF_FFFF_FFFF, 0);
        check_res("R6 R7 widen compact", {52'd0, 16'hA5C3}, 1);
        // R6: compact add sharer node 20 -> bit 20, no longer fits
        do_op(1, 1, 16'h0001, 68'd0, 20);
        check_res("R6 R7 compact add", {47'd0, 1'b1, 19'd0, 1'b1}, 0);
        // R6: expanded pass-through unchanged
        do_op(0, 0, 16'hFFFF, mk(0, 3, 64'h0000_0000_0000_1234), 0);
        check_res("R6 R7 expanded pass", mk(0, 3, 64'h1234), 0);
        // R8: single-cycle pulse
        @(negedge clk);
        chk(res_valid === 0, "R8 pulse ends", 68'(res_valid), 68'd0);
    endtask

    task automatic fan(input string tag, input logic [67:0] e, input int req,
                       input int rmode, input bit restart);
        int exp_n = 0;
        int got_n = 0;
        int exp_l[600];
        int got_l[600];
        int cyc = 0;
        int cnt_at_done = -1;
        bit seq_ok = 1;
        for (int n = 0; n < 512; n++) begin
            bit m;
            if (e[67]) m = e[n / 8];
            else       m = (n / 64 == int'(e[66:64])) && e[n % 64];
            if (m && n != req) begin exp_l[exp_n] = n; exp_n++; end
        end
        @(negedge clk);
        inv_entry = e; inv_req_node = 9'(req); inv_start = 1;
        @(negedge clk);
        inv_start = 0;
        while (cyc < 3000) begin
            case (rmode)
                0: inv_ready = 1;
                1: inv_ready = cyc[0];
                default: inv_ready = (cyc % 3 == 2);
            endcase
            if (restart && cyc == 2) begin
                inv_start = 1; inv_entry = mk(0, 7, 64'hFFFF); inv_req_node = 0;
            end else begin
                inv_start = 0;
            end
            #0.1;
            if (inv_valid && inv_ready && got_n < 600) begin
                got_l[got_n] = int'(inv_node); got_n++;
            end
            if (inv_done) begin cnt_at_done = int'(inv_count); break; end
            @(negedge clk);
            cyc++;
        end
        inv_start = 0;
        inv_ready = 0;
        chk(got_n == exp_n, {tag, " message count"}, 68'(got_n), 68'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (got_l[i] != exp_l[i]) seq_ok = 0;
        chk(seq_ok, {tag, " node sequence"}, 68'(got_n > 0 ? got_l[0] : -1),
            68'(exp_n > 0 ? exp_l[0] : -1));
        chk(cnt_at_done == exp_n, {tag, " R13 inv_count"}, 68'(cnt_at_done), 68'(exp_n));
        @(negedge clk);
        chk(inv_busy === 0 && inv_done === 0, {tag, " idle after"},
            {66'd0, inv_busy, inv_done}, 68'd0);
        chk(int'(inv_count) == exp_n, {tag, " R13 count held"}, 68'(inv_count), 68'(exp_n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_update();
        fan("R9 R11 full", mk(0, 2, bits(0, 5, 63)), 133, 0, 0);
        fan("R9 full stalled R12", mk(0, 6, 64'hF00F_0000_8001_0003), 0, 2, 0);
        fan("R10 R11 coarse", mk(1, 0, bits(1, 40, -1)), 10, 1, 0);
        fan("R10 coarse edges", mk(1, 0, bits(0, 63, -1)), 511, 2, 0);
        fan("R13 empty", 68'd0, 0, 0, 0);
        fan("R14 start while busy", mk(0, 0, bits(2, 9, 30)), 9, 1, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule